// File: doc/BRIEF.md
# Global 64-bit Counter Timer with Self-Rearming Comparator

This block is a register-mapped system timer. A 64-bit up-counter, visible to software as a low word and a high word, can be preloaded while stopped and then started. It advances by one per clock and carries from the low word into the high word. Software that needs a coherent 64-bit value reads the high word, then the low word, then the high word again, and retries when the two high reads differ.

A single 64-bit comparator watches the counter. When the comparator is enabled and the counter equals the compare value, a sticky interrupt flag is raised. The `irq` output is that flag gated by an enable bit. In periodic mode every match also adds a stored 32-bit increment to the compare value, so interrupts repeat at a fixed spacing without software rewriting the compare value.

Every write to a timing register is confirmed through a sticky "write applied" bit of its own. Software polls for the bit and then clears it by writing 1. The bus is a plain 32-bit write port and a combinational read port with 12-bit byte offsets.

Top module: `sys_count_timer`

## Requirements
- R1: After reset the counter, compare value, increment, control, interrupt flag, interrupt enable and all write-applied bits read as zero, and `irq` is low.
- R2: While control bit 8 (run) is clear, the counter holds its value. A write to offset 0x100 loads the low word and a write to 0x104 loads the high word.
- R3: While run is set, the counter goes up by one on every clock, and the low word carries into the high word.
- R4: With control bit 0 (compare enable) set, a counter value equal to the 64-bit compare value {0x204, 0x200} sets bit 0 of 0x244 on the following clock. The bit stays set until software writes 1 to it.
- R5: `irq` is high exactly when bit 0 of 0x244 and bit 0 of 0x248 are both set.
- R6: With control bit 1 (periodic) set, each match adds the 32-bit value at 0x208 to the compare value on the following clock.
- R7: A write to 0x100 or 0x104 sets bit 0 or bit 1, respectively, of 0x110 one clock after the write takes effect. Writing 1 to a bit of 0x110 clears it.
- R8: Writes to 0x200, 0x204, 0x208 and 0x240 set bits 0, 1, 2 and 16 of 0x24C one clock after the write takes effect. Writing 1 to a bit clears it.
- R9: Reads of unmapped offsets return zero. The control register reads back only bits 8, 1 and 0.
- R10: With compare enable clear, equality of counter and compare value leaves the interrupt flag clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, applied on the rising clock edge |
| wr_addr | input | 12 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 12 | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq | output | 1 | Comparator interrupt, flag AND enable |

## Verification
The counter is swept over run lengths from 0 to 40 cycles, starting just below a low-word rollover. This separates a missing carry and an off-by-one in the start or stop edge from correct counting. Matches are tried with compare offsets 0, 1, 2, 5 and 13, and with a compare value in a nonzero high word. The flag is checked on every cycle, so a match that comes one cycle early or late, or that compares only the low word, shows up. Periodic mode is followed cycle by cycle across several matches against an arithmetically derived compare value. Each write-applied bit is checked for its one-cycle delay and its write-1 clear, and a disabled comparator is run through an equality.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BUS_AW = 12;

  localparam logic [BUS_AW-1:0] OFS_CNT_LO  = 12'h100;
  localparam logic [BUS_AW-1:0] OFS_CNT_HI  = 12'h104;
  localparam logic [BUS_AW-1:0] OFS_CNT_WS  = 12'h110;
  localparam logic [BUS_AW-1:0] OFS_CMP_LO  = 12'h200;
  localparam logic [BUS_AW-1:0] OFS_CMP_HI  = 12'h204;
  localparam logic [BUS_AW-1:0] OFS_CMP_INC = 12'h208;
  localparam logic [BUS_AW-1:0] OFS_CTRL    = 12'h240;
  localparam logic [BUS_AW-1:0] OFS_ISTAT   = 12'h244;
  localparam logic [BUS_AW-1:0] OFS_IEN     = 12'h248;
  localparam logic [BUS_AW-1:0] OFS_REG_WS  = 12'h24C;

  localparam int unsigned CTL_CMP_EN_BIT = 0;
  localparam int unsigned CTL_AUTO_BIT   = 1;
  localparam int unsigned CTL_RUN_BIT    = 8;
  localparam int unsigned WS_CTRL_BIT    = 16;

  // internal write-applied vector positions
  localparam int unsigned WA_CNT_LO = 0;
  localparam int unsigned WA_CNT_HI = 1;
  localparam int unsigned WA_CMP_LO = 2;
  localparam int unsigned WA_CMP_HI = 3;
  localparam int unsigned WA_INC    = 4;
  localparam int unsigned WA_CTRL   = 5;
  localparam int unsigned WA_NUM    = 6;

  typedef struct packed {
    logic run;
    logic auto_inc;
    logic cmp_en;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  ld_lo,
  input  logic                  ld_hi,
  input  logic [HALF_W-1:0]     ld_data,
  output logic [2*HALF_W-1:0]   cnt_q
);
  localparam int unsigned CW = 2 * HALF_W;

  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = run | ld_lo | ld_hi;
    if (ld_lo || ld_hi) begin
      if (ld_lo) cnt_d[HALF_W-1:0]  = ld_data;
      if (ld_hi) cnt_d[CW-1:HALF_W] = ld_data;
    end else if (run) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ld_lo && !ld_hi) |=> (cnt_q == $past(cnt_q) + CW'(1))); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_lo && !ld_hi) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int unsigned HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic                  wr_inc,
  input  logic [HALF_W-1:0]     wr_data,
  input  logic [2*HALF_W-1:0]   cnt,
  input  logic                  cmp_en,
  input  logic                  auto_en,
  output logic                  match,
  output logic [2*HALF_W-1:0]   cmp_q,
  output logic [HALF_W-1:0]     inc_q
);
  localparam int unsigned CW = 2 * HALF_W;

  logic [CW-1:0] cmp_d;
  logic          cmp_ce;
  logic          rearm;

  assign match = cmp_en && (cnt == cmp_q);
  assign rearm = match && auto_en;

  always_comb begin
    cmp_d  = cmp_q;
    cmp_ce = wr_lo | wr_hi | rearm;
    if (wr_lo || wr_hi) begin
      if (wr_lo) cmp_d[HALF_W-1:0]  = wr_data;
      if (wr_hi) cmp_d[CW-1:HALF_W] = wr_data;
    end else if (rearm) begin
      cmp_d = cmp_q + {{HALF_W{1'b0}}, inc_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_ce) cmp_q <= cmp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      inc_q <= '0;
    else if (wr_inc) inc_q <= wr_data;
  end

  AST_AUTO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (match && auto_en && !wr_lo && !wr_hi) |=>
      (cmp_q == $past(cmp_q) + {{HALF_W{1'b0}}, $past(inc_q)})); // R6
  AST_CMP_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!match && !wr_lo && !wr_hi) |=> $stable(cmp_q)); // R6
endmodule

// File: rtl/tmr_w1c_bits.sv
module tmr_w1c_bits #(
  parameter int unsigned N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q[i] <= 1'b0;
      else if (set[i] || clr[i]) q[i] <= set[i];
    end

    AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]); // R7
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!set[i] && !clr[i]) |=> $stable(q[i])); // R8
  end
endmodule

// File: rtl/sys_count_timer.sv
module sys_count_timer #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [tmr_pkg::BUS_AW-1:0]  wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [tmr_pkg::BUS_AW-1:0]  rd_addr,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        irq
);
  import tmr_pkg::*;

  localparam int unsigned CNT_W = 2 * DATA_W;

  // write decode
  logic sel_cnt_lo, sel_cnt_hi, sel_cnt_ws, sel_cmp_lo, sel_cmp_hi;
  logic sel_inc, sel_ctrl, sel_istat, sel_ien, sel_reg_ws;

  always_comb begin
    sel_cnt_lo = wr_en && (wr_addr == OFS_CNT_LO);
    sel_cnt_hi = wr_en && (wr_addr == OFS_CNT_HI);
    sel_cnt_ws = wr_en && (wr_addr == OFS_CNT_WS);
    sel_cmp_lo = wr_en && (wr_addr == OFS_CMP_LO);
    sel_cmp_hi = wr_en && (wr_addr == OFS_CMP_HI);
    sel_inc    = wr_en && (wr_addr == OFS_CMP_INC);
    sel_ctrl   = wr_en && (wr_addr == OFS_CTRL);
    sel_istat  = wr_en && (wr_addr == OFS_ISTAT);
    sel_ien    = wr_en && (wr_addr == OFS_IEN);
    sel_reg_ws = wr_en && (wr_addr == OFS_REG_WS);
  end

  // control and interrupt enable
  tmr_ctrl_t ctrl_q, ctrl_d;
  logic      ien_q;

  always_comb begin
    ctrl_d          = ctrl_q;
    ctrl_d.run      = wr_data[CTL_RUN_BIT];
    ctrl_d.auto_inc = wr_data[CTL_AUTO_BIT];
    ctrl_d.cmp_en   = wr_data[CTL_CMP_EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= '0;
    else if (sel_ctrl) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ien_q <= 1'b0;
    else if (sel_ien) ien_q <= wr_data[0];
  end

  // counter and comparator
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cmp_q;
  logic [DATA_W-1:0] inc_q;
  logic              match;

  tmr_counter #(.HALF_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.run),
    .ld_lo   (sel_cnt_lo),
    .ld_hi   (sel_cnt_hi),
    .ld_data (wr_data),
    .cnt_q   (cnt_q)
  );

  tmr_compare #(.HALF_W(DATA_W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lo   (sel_cmp_lo),
    .wr_hi   (sel_cmp_hi),
    .wr_inc  (sel_inc),
    .wr_data (wr_data),
    .cnt     (cnt_q),
    .cmp_en  (ctrl_q.cmp_en),
    .auto_en (ctrl_q.auto_inc),
    .match   (match),
    .cmp_q   (cmp_q),
    .inc_q   (inc_q)
  );

  // interrupt flag
  logic istat_q;

  tmr_w1c_bits #(.N(1)) u_istat (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (match),
    .clr   (sel_istat & wr_data[0]),
    .q     (istat_q)
  );

  assign irq = istat_q & ien_q;

  // write-applied tracking: pending one cycle after the write lands
  logic [WA_NUM-1:0] wa_pend_d, wa_pend_q, wa_clr, wa_q;

  always_comb begin
    wa_pend_d            = '0;
    wa_pend_d[WA_CNT_LO] = sel_cnt_lo;
    wa_pend_d[WA_CNT_HI] = sel_cnt_hi;
    wa_pend_d[WA_CMP_LO] = sel_cmp_lo;
    wa_pend_d[WA_CMP_HI] = sel_cmp_hi;
    wa_pend_d[WA_INC]    = sel_inc;
    wa_pend_d[WA_CTRL]   = sel_ctrl;

    wa_clr            = '0;
    wa_clr[WA_CNT_LO] = sel_cnt_ws & wr_data[0];
    wa_clr[WA_CNT_HI] = sel_cnt_ws & wr_data[1];
    wa_clr[WA_CMP_LO] = sel_reg_ws & wr_data[0];
    wa_clr[WA_CMP_HI] = sel_reg_ws & wr_data[1];
    wa_clr[WA_INC]    = sel_reg_ws & wr_data[2];
    wa_clr[WA_CTRL]   = sel_reg_ws & wr_data[WS_CTRL_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wa_pend_q <= '0;
    else        wa_pend_q <= wa_pend_d;
  end

  tmr_w1c_bits #(.N(WA_NUM)) u_wa (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (wa_pend_q),
    .clr   (wa_clr),
    .q     (wa_q)
  );

  // read mux
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFS_CNT_LO:  rd_data = cnt_q[DATA_W-1:0];
      OFS_CNT_HI:  rd_data = cnt_q[CNT_W-1:DATA_W];
      OFS_CNT_WS: begin
        rd_data[0] = wa_q[WA_CNT_LO];
        rd_data[1] = wa_q[WA_CNT_HI];
      end
      OFS_CMP_LO:  rd_data = cmp_q[DATA_W-1:0];
      OFS_CMP_HI:  rd_data = cmp_q[CNT_W-1:DATA_W];
      OFS_CMP_INC: rd_data = inc_q;
      OFS_CTRL: begin
        rd_data[CTL_RUN_BIT]    = ctrl_q.run;
        rd_data[CTL_AUTO_BIT]   = ctrl_q.auto_inc;
        rd_data[CTL_CMP_EN_BIT] = ctrl_q.cmp_en;
      end
      OFS_ISTAT:   rd_data[0] = istat_q;
      OFS_IEN:     rd_data[0] = ien_q;
      OFS_REG_WS: begin
        rd_data[0]           = wa_q[WA_CMP_LO];
        rd_data[1]           = wa_q[WA_CMP_HI];
        rd_data[2]           = wa_q[WA_INC];
        rd_data[WS_CTRL_BIT] = wa_q[WA_CTRL];
      end
      default:     rd_data = '0;
    endcase
  end

  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> istat_q); // R4
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.cmp_en && !istat_q) |=> !istat_q); // R10
  AST_WA_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_cmp_lo && !wa_q[WA_CMP_LO]) |=> !wa_q[WA_CMP_LO]); // R8
endmodule

// File: tb/tb_sys_count_timer.sv
module tb_sys_count_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sys_count_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // called at a negedge; write lands on the next posedge; returns at the next negedge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic load_cnt(input logic [63:0] v);
    wr(12'h240, 32'h0);
    wr(12'h100, v[31:0]);
    wr(12'h104, v[63:32]);
  endtask

  // match timing: flag must appear exactly delta+1 cycles after the start edge
  task automatic run_match(input logic [63:0] start, input logic [63:0] cmpv);
    logic [31:0] r;
    logic [63:0] delta;
    delta = cmpv - start;
    load_cnt(start);
    wr(12'h200, cmpv[31:0]);
    wr(12'h204, cmpv[63:32]);
    wr(12'h244, 32'h1);
    wr(12'h248, 32'h1);
    wr(12'h240, 32'h101);
    for (int k = 0; k <= int'(delta) + 2; k++) begin
      rd(12'h244, r);
      chk("R4 flag timing", {63'b0, r[0]}, {63'b0, (k >= int'(delta) + 1)});
      chk("R5 irq follows flag", {63'b0, irq}, {63'b0, (k >= int'(delta) + 1)});
      @(negedge clk);
    end
    wr(12'h240, 32'h0);
    wr(12'h244, 32'h1);
    rd(12'h244, r);
    chk("R4 flag write-1 clear", {63'b0, r[0]}, 64'h0);
  endtask

  initial begin
    logic [31:0] r, lo, hi;
    logic [63:0] st, e;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    begin
      logic [11:0] regs [10] = '{12'h100, 12'h104, 12'h110, 12'h200, 12'h204,
                                  12'h208, 12'h240, 12'h244, 12'h248, 12'h24C};
      for (int i = 0; i < 10; i++) begin
        rd(regs[i], r);
        chk("R1 reset value", {32'b0, r}, 64'h0);
      end
      chk("R1 irq low", {63'b0, irq}, 64'h0);
    end

    // R9 unmapped reads and control readback
    begin
      logic [11:0] holes [6] = '{12'h000, 12'h108, 12'h10C, 12'h20C, 12'h250, 12'hFFC};
      for (int i = 0; i < 6; i++) begin
        rd(holes[i], r);
        chk("R9 unmapped read", {32'b0, r}, 64'h0);
      end
    end
    wr(12'h240, 32'hFFFF_FFFF);
    rd(12'h240, r);
    chk("R9 control bits", {32'b0, r}, 64'h103);
    wr(12'h240, 32'h0);
    wr(12'h244, 32'h1);

    // R7 counter write-applied bits
    wr(12'h24C, 32'h0001_0007);
    wr(12'h110, 32'h3);
    wr(12'h100, 32'h5);
    rd(12'h110, r);
    chk("R7 lo bit not yet", {32'b0, r}, 64'h0);
    @(negedge clk);
    rd(12'h110, r);
    chk("R7 lo bit set", {32'b0, r}, 64'h1);
    wr(12'h104, 32'h6);
    @(negedge clk);
    rd(12'h110, r);
    chk("R7 both bits", {32'b0, r}, 64'h3);
    wr(12'h110, 32'h1);
    rd(12'h110, r);
    chk("R7 clear lo only", {32'b0, r}, 64'h2);
    wr(12'h110, 32'h2);
    rd(12'h110, r);
    chk("R7 clear hi", {32'b0, r}, 64'h0);

    // R8 register write-applied bits
    begin
      logic [11:0] ra [4] = '{12'h200, 12'h204, 12'h208, 12'h240};
      logic [31:0] bm [4] = '{32'h1, 32'h2, 32'h4, 32'h1_0000};
      for (int i = 0; i < 4; i++) begin
        wr(ra[i], 32'h0);
        rd(12'h24C, r);
        chk("R8 bit not yet", {32'b0, r}, 64'h0);
        @(negedge clk);
        rd(12'h24C, r);
        chk("R8 bit set", {32'b0, r}, {32'b0, bm[i]});
        wr(12'h24C, bm[i]);
        rd(12'h24C, r);
        chk("R8 bit cleared", {32'b0, r}, 64'h0);
      end
    end

    // R3 sweep of run length across a low-word rollover
    for (int n = 0; n <= 40; n++) begin
      st = 64'h0000_0002_FFFF_FFF0;
      load_cnt(st);
      wr(12'h240, 32'h100);
      repeat (n) @(negedge clk);
      wr(12'h240, 32'h0);
      rd(12'h100, lo);
      rd(12'h104, hi);
      e = st + 64'(n + 1);
      chk("R3 count and carry", {hi, lo}, e);
      if (n == 40) begin
        // R2 hold while stopped
        repeat (5) @(negedge clk);
        rd(12'h100, lo);
        rd(12'h104, hi);
        chk("R2 hold while stopped", {hi, lo}, e);
      end
    end
    load_cnt(64'h1234_5678_9ABC_DEF0);
    rd(12'h100, lo);
    rd(12'h104, hi);
    chk("R2 direct load", {hi, lo}, 64'h1234_5678_9ABC_DEF0);

    // R4 / R5 match timing, several offsets and a full-width compare
    run_match(64'h0, 64'h0);
    run_match(64'h0, 64'h1);
    run_match(64'h0, 64'h2);
    run_match(64'h0, 64'h5);
    run_match(64'h0, 64'd13);
    run_match(64'h1_FFFF_FFFE, 64'h2_0000_0001);

    // R5 enable gating
    load_cnt(64'h0);
    wr(12'h200, 32'h2);
    wr(12'h204, 32'h0);
    wr(12'h248, 32'h0);
    wr(12'h240, 32'h101);
    repeat (6) @(negedge clk);
    wr(12'h240, 32'h0);
    rd(12'h244, r);
    chk("R5 flag set while gated", {32'b0, r}, 64'h1);
    chk("R5 irq gated off", {63'b0, irq}, 64'h0);
    wr(12'h248, 32'h1);
    chk("R5 irq after enable", {63'b0, irq}, 64'h1);
    wr(12'h244, 32'h1);
    chk("R5 irq after clear", {63'b0, irq}, 64'h0);

    // R10 comparator disabled
    load_cnt(64'h0);
    wr(12'h200, 32'h5);
    wr(12'h240, 32'h100);
    repeat (20) @(negedge clk);
    wr(12'h240, 32'h0);
    rd(12'h244, r);
    chk("R10 no flag when disabled", {32'b0, r}, 64'h0);

    // R6 periodic re-arm, followed every cycle
    load_cnt(64'h0);
    wr(12'h200, 32'd10);
    wr(12'h204, 32'h0);
    wr(12'h208, 32'd7);
    wr(12'h244, 32'h1);
    wr(12'h240, 32'h103);
    for (int k = 0; k <= 60; k++) begin
      e = 64'd10;
      while (e + 1 <= 64'(k)) e = e + 7;
      rd(12'h200, lo);
      chk("R6 compare advance", {32'b0, lo}, e);
      @(negedge clk);
    end
    wr(12'h240, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule